// File: doc/BRIEF.md
# Segmented Frame Boundary Decoder

This block sits on a segmented client bus made of a valid strobe, an in-frame vector with one bit per data segment, and a wide data word cut into the same number of segments. On every cycle where valid is high, it compares the in-frame vector with the vector from the previous accepted cycle. From that comparison it reports start-of-packet and end-of-packet events, the segment index of each event, and whether the data word carries packet content at all.

A start is recognised when a non-zero vector follows an all-zero one. Its position is the lowest set bit. An end is recognised when an all-zero vector follows a non-zero one. Its position is the highest set bit of that last non-zero vector. The end cannot be known until the following all-zero vector arrives, so the end event appears one accepted cycle after the last packet beat. Every output is registered, one clock after the input.

The block handles one packet boundary per cycle. Payload storage, framing bytes and flow control are left to neighbouring logic.

Top module: `seg_boundary_decoder`

## Requirements
- R1: After reset, every output is zero, and the recorded previous vector counts as all zeros.
- R2: One clock after an accepted cycle (in_valid high) whose in-frame vector is non-zero, out_sop is high if the previous accepted vector was all zeros. This includes the first accepted cycle after reset.
- R3: With out_sop high, out_sop_seg equals the index of the lowest set bit of the start-cycle in-frame vector. Bit 0 is segment 0.
- R4: One clock after an accepted all-zero vector that follows an accepted non-zero vector, out_eop is high. out_eop_seg then equals the index of the highest set bit of that last non-zero vector.
- R5: One clock after an accepted cycle, out_has_data equals the OR of the in-frame bits and out_seg_mask equals the in-frame vector. Segment i of out_data occupies bits [i*SEG_W +: SEG_W]; it carries in_data's segment i when in-frame bit i is set and is zero otherwise. An all-zero vector therefore yields all-zero data.
- R6: A cycle with in_valid low produces out_valid, out_sop, out_eop, out_has_data, out_seg_mask and out_data all zero one clock later. It leaves the recorded history unchanged, so boundaries are judged across such gaps.
- R7: out_sop_seg is zero whenever out_sop is low, and out_eop_seg is zero whenever out_eop is low.
- R8: Consecutive accepted non-zero vectors raise neither out_sop nor out_eop after the first one. Consecutive accepted all-zero vectors raise neither after the first one.
- R9: out_valid equals in_valid delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bus cycle accepted when high |
| in_frame | input | SEG_COUNT | Per-segment packet-content flags |
| in_data | input | SEG_COUNT*SEG_W | Segmented data word |
| out_valid | output | 1 | Registered copy of in_valid |
| out_sop | output | 1 | Start-of-packet event |
| out_sop_seg | output | clog2(SEG_COUNT) | Start segment index |
| out_eop | output | 1 | End-of-packet event (one accepted cycle late) |
| out_eop_seg | output | clog2(SEG_COUNT) | End segment index |
| out_has_data | output | 1 | Accepted cycle carried packet content |
| out_seg_mask | output | SEG_COUNT | Registered in-frame vector |
| out_data | output | SEG_COUNT*SEG_W | Data with empty segments zeroed |

## Verification
A corrupted previous-vector register shows at the ports on the next accepted cycle. It appears as a missing or spurious start or end strobe, or as a start reported in the middle of a packet. A wrong held end index stays hidden until the packet closes, and then shows as a bad out_eop_seg. For this reason the directed cases include packets of one and of many beats and packets that close across invalid gaps. A random stream compared against a bench model then exercises every cycle of the bus.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   typedef enum logic {
      PICK_LOWEST  = 1'b0,
      PICK_HIGHEST = 1'b1
   } pick_e;
endpackage

// File: rtl/sbd_prio_enc.sv
module sbd_prio_enc
   import sbd_pkg::*;
#(
   parameter int    WIDTH = 16,
   parameter int    IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
   parameter pick_e PICK  = PICK_LOWEST
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         initial $error("sbd_prio_enc: WIDTH must be at least 2");
      end
      if ((1 << IDX_W) < WIDTH) begin : g_bad_idx
         initial $error("sbd_prio_enc: IDX_W too narrow for WIDTH");
      end
   endgenerate

   assign any = |vec;

   generate
      if (PICK == PICK_LOWEST) begin : g_lowest
         // scan downward so the lowest set bit is written last
         always_comb begin
            idx = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
         // R3: no set bit below the chosen index
         always_comb begin
            if (any) begin
               assert_lowest_clear_R3 : assert ((vec & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0);
            end
         end
      end else begin : g_highest
         always_comb begin
            idx = '0;
            for (int i = 0; i < WIDTH; i++) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
         // R4: no set bit above the chosen index
         always_comb begin
            if (any) begin
               assert_highest_clear_R4 : assert ((vec >> idx) == WIDTH'(1));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbd_history.sv
module sbd_history #(
   parameter int WIDTH = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [WIDTH-1:0] frame,
   input  logic [IDX_W-1:0] frame_hi_idx,
   output logic [WIDTH-1:0] prev_frame,
   output logic [IDX_W-1:0] held_hi_idx
);
   logic [WIDTH-1:0] prev_q;
   logic [IDX_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         hold_q <= '0;
      end else if (accept) begin
         prev_q <= frame;
         if (|frame) hold_q <= frame_hi_idx;
      end
   end

   assign prev_frame  = prev_q;
   assign held_hi_idx = hold_q;

   // R6: history frozen on cycles that are not accepted
   assert_hist_frozen_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(prev_q) && $stable(hold_q)));

   // R2: accepted vector becomes the history
   assert_hist_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (prev_q == $past(frame)));
endmodule

// File: rtl/sbd_seg_mask.sv
module sbd_seg_mask #(
   parameter int SEGS  = 16,
   parameter int SEG_W = 8,
   localparam int DW   = SEGS * SEG_W
) (
   input  logic [SEGS-1:0] frame,
   input  logic [DW-1:0]   data_in,
   output logic [DW-1:0]   data_out
);
   generate
      for (genvar s = 0; s < SEGS; s++) begin : g_seg
         assign data_out[s*SEG_W +: SEG_W] = frame[s] ? data_in[s*SEG_W +: SEG_W] : '0;
      end
   endgenerate
endmodule

// File: rtl/seg_boundary_decoder.sv
module seg_boundary_decoder
   import sbd_pkg::*;
#(
   parameter int SEG_COUNT = 16,
   parameter int SEG_W     = 8,
   localparam int IDX_W    = $clog2(SEG_COUNT),
   localparam int DATA_W   = SEG_COUNT * SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SEG_COUNT-1:0] in_frame,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_sop,
   output logic [IDX_W-1:0]  out_sop_seg,
   output logic              out_eop,
   output logic [IDX_W-1:0]  out_eop_seg,
   output logic              out_has_data,
   output logic [SEG_COUNT-1:0] out_seg_mask,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (SEG_COUNT < 2 || SEG_COUNT > 1024) begin : g_bad_segs
         initial $error("seg_boundary_decoder: SEG_COUNT out of range");
      end
      if (SEG_W < 1) begin : g_bad_segw
         initial $error("seg_boundary_decoder: SEG_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]     lo_idx, hi_idx, held_idx;
   logic                 frame_nz, hi_any;
   logic [SEG_COUNT-1:0] prev_frame;
   logic [DATA_W-1:0]    masked;
   logic                 sop_c, eop_c;

   sbd_prio_enc #(.WIDTH(SEG_COUNT), .IDX_W(IDX_W), .PICK(PICK_LOWEST)) u_lo (
      .vec(in_frame), .idx(lo_idx), .any(frame_nz)
   );

   sbd_prio_enc #(.WIDTH(SEG_COUNT), .IDX_W(IDX_W), .PICK(PICK_HIGHEST)) u_hi (
      .vec(in_frame), .idx(hi_idx), .any(hi_any)
   );

   sbd_history #(.WIDTH(SEG_COUNT), .IDX_W(IDX_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .accept(in_valid), .frame(in_frame),
      .frame_hi_idx(hi_idx), .prev_frame(prev_frame), .held_hi_idx(held_idx)
   );

   sbd_seg_mask #(.SEGS(SEG_COUNT), .SEG_W(SEG_W)) u_mask (
      .frame(in_frame), .data_in(in_data), .data_out(masked)
   );

   assign sop_c = in_valid &  frame_nz & ~(|prev_frame);
   assign eop_c = in_valid & ~frame_nz &  (|prev_frame);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_sop      <= 1'b0;
         out_sop_seg  <= '0;
         out_eop      <= 1'b0;
         out_eop_seg  <= '0;
         out_has_data <= 1'b0;
         out_seg_mask <= '0;
         out_data     <= '0;
      end else begin
         out_valid    <= in_valid;
         out_sop      <= sop_c;
         out_sop_seg  <= sop_c ? lo_idx : '0;
         out_eop      <= eop_c;
         out_eop_seg  <= eop_c ? held_idx : '0;
         out_has_data <= in_valid & frame_nz;
         out_seg_mask <= in_valid ? in_frame : '0;
         out_data     <= in_valid ? masked : '0;
      end
   end

   // R2 / R4: start and end never in the same cycle
   assert_sop_eop_excl_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(out_sop && out_eop));

   // R7: indices parked at zero without their strobe
   assert_sop_seg_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !out_sop |-> (out_sop_seg == '0));
   assert_eop_seg_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !out_eop |-> (out_eop_seg == '0));

   // R6: nothing reported for a cycle that was not accepted
   assert_idle_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_sop && !out_eop && !out_has_data && out_seg_mask == '0));

   // R3: the start segment is marked in the reported mask
   assert_sop_in_mask_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_seg_mask[out_sop_seg]);

   // R5: content flag agrees with the mask
   assert_has_data_mask_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      out_has_data == (out_seg_mask != '0));

   // R9: valid is a one-clock delay of the input
   assert_valid_delay_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R4: an end is only reported on an empty accepted cycle
   assert_eop_empty_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> (out_valid && !out_has_data));
endmodule

// File: tb/test_seg_boundary_decoder.sv
`timescale 1ns/1ps
module test_seg_boundary_decoder;
   localparam int N  = 16;
   localparam int SW = 8;
   localparam int IW = $clog2(N);
   localparam int DW = N * SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [N-1:0]  in_frame = '0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid, out_sop, out_eop, out_has_data;
   logic [IW-1:0] out_sop_seg, out_eop_seg;
   logic [N-1:0]  out_seg_mask;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] m_prev = '0;

   always #10 clk = ~clk;

   seg_boundary_decoder #(.SEG_COUNT(N), .SEG_W(SW)) i_seg_boundary_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
      .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
      .out_sop_seg(out_sop_seg), .out_eop(out_eop), .out_eop_seg(out_eop_seg),
      .out_has_data(out_has_data), .out_seg_mask(out_seg_mask), .out_data(out_data)
   );

   function automatic logic [IW-1:0] low_bit(input logic [N-1:0] v);
      for (int i = N - 1; i >= 0; i--) if (v[i]) low_bit = IW'(i);
      if (v == '0) low_bit = '0;
   endfunction

   function automatic logic [IW-1:0] high_bit(input logic [N-1:0] v);
      high_bit = '0;
      for (int i = 0; i < N; i++) if (v[i]) high_bit = IW'(i);
   endfunction

   function automatic logic [DW-1:0] rand_data();
      logic [DW-1:0] d;
      for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
      return d;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle, checked against the requirement model one clock later
   task automatic step(input logic v, input logic [N-1:0] f, input logic [DW-1:0] d);
      logic e_sop, e_eop;
      logic [IW-1:0] e_sidx, e_eidx;
      logic [DW-1:0] e_data;
      @(negedge clk);
      in_valid = v; in_frame = f; in_data = d;
      e_sop = v && (f != '0) && (m_prev == '0);
      e_eop = v && (f == '0) && (m_prev != '0);
      e_sidx = e_sop ? low_bit(f) : '0;
      e_eidx = e_eop ? high_bit(m_prev) : '0;
      for (int s = 0; s < N; s++) e_data[s*SW +: SW] = (v && f[s]) ? d[s*SW +: SW] : '0;
      if (v) m_prev = f;
      @(posedge clk); #1;
      chk("R9 out_valid", DW'(out_valid), DW'(v));
      chk("R2 out_sop", DW'(out_sop), DW'(e_sop));
      chk("R3 R7 out_sop_seg", DW'(out_sop_seg), DW'(e_sidx));
      chk("R4 out_eop", DW'(out_eop), DW'(e_eop));
      chk("R4 R7 out_eop_seg", DW'(out_eop_seg), DW'(e_eidx));
      chk("R5 R6 out_has_data", DW'(out_has_data), DW'(v && f != '0));
      chk("R5 R6 out_seg_mask", DW'(out_seg_mask), DW'(v ? f : '0));
      chk("R5 R6 out_data", out_data, e_data);
   endtask

   task automatic t_reset();  // R1
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 out_valid", DW'(out_valid), '0);
      chk("R1 out_sop", DW'(out_sop), '0);
      chk("R1 out_eop", DW'(out_eop), '0);
      chk("R1 out_seg_mask", DW'(out_seg_mask), '0);
      chk("R1 out_data", out_data, '0);
      @(negedge clk); rst_n = 1'b1;
      m_prev = '0;
   endtask

   task automatic t_first_start();  // R1 R2: first accepted non-zero vector starts a packet
      step(1'b1, 16'h0004, rand_data());
      chk("R2 first start", DW'(out_sop), DW'(1));
      chk("R3 first start seg", DW'(out_sop_seg), DW'(2));
      step(1'b1, 16'h0000, rand_data());
      chk("R4 end seg 2", DW'(out_eop_seg), DW'(2));
   endtask

   task automatic t_multi_beat();  // R2 R3 R4 R8
      step(1'b1, 16'h00F8, rand_data());
      chk("R3 start seg 3", DW'(out_sop_seg), DW'(3));
      step(1'b1, 16'hFFFF, rand_data());
      chk("R8 mid no sop", DW'(out_sop), '0);
      step(1'b1, 16'h0F00, rand_data());
      chk("R8 mid no eop", DW'(out_eop), '0);
      step(1'b1, 16'h0000, rand_data());
      chk("R4 end seg 11", DW'(out_eop_seg), DW'(11));
      step(1'b1, 16'h0000, rand_data());
      chk("R8 idle no eop", DW'(out_eop), '0);
   endtask

   task automatic t_edges();  // R3 R4 extreme segments
      step(1'b1, 16'h8000, rand_data());
      chk("R3 start seg 15", DW'(out_sop_seg), DW'(15));
      step(1'b1, 16'h0001, rand_data());
      step(1'b1, 16'h0000, rand_data());
      chk("R4 end seg 0", DW'(out_eop_seg), DW'(0));
      step(1'b1, 16'hFFFF, rand_data());
      chk("R3 start seg 0", DW'(out_sop_seg), DW'(0));
      step(1'b1, 16'h0000, rand_data());
      chk("R4 end seg 15", DW'(out_eop_seg), DW'(15));
   endtask

   task automatic t_gaps();  // R6: invalid cycles ignored, boundaries judged across them
      step(1'b1, 16'h0300, rand_data());
      step(1'b0, 16'h0000, rand_data());
      step(1'b0, 16'hFFFF, rand_data());
      chk("R6 gap quiet", DW'(out_has_data), '0);
      step(1'b1, 16'h0000, rand_data());
      chk("R6 end across gap", DW'(out_eop), DW'(1));
      chk("R6 end seg 9", DW'(out_eop_seg), DW'(9));
      step(1'b0, 16'h0040, rand_data());
      chk("R6 no start on invalid", DW'(out_sop), '0);
      step(1'b1, 16'h0040, rand_data());
      chk("R6 start after gap", DW'(out_sop), DW'(1));
      step(1'b1, 16'h0000, rand_data());
   endtask

   task automatic t_idle_data();  // R5: valid with empty vector gives no content
      step(1'b1, 16'h0000, {DW{1'b1}});
      chk("R5 empty data zero", out_data, '0);
      step(1'b1, 16'h0010, rand_data());
      step(1'b1, 16'h0000, rand_data());
      chk("R4 single beat end seg 4", DW'(out_eop_seg), DW'(4));
   endtask

   task automatic t_random();  // R2-R9 against the model
      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] f;
         f = ($urandom_range(0, 2) == 0) ? '0 : N'($urandom);
         step($urandom_range(0, 3) != 0, f, rand_data());
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_first_start();
      t_multi_beat();
      t_edges();
      t_gaps();
      t_idle_data();
      t_random();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule